// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

This block keeps the transmit-side state of a bank of message mailboxes and decides which pending mailbox is handed to the bus next. Each mailbox has an enable bit, a direction bit (0 = transmit, 1 = receive), a transmit-request bit, a transmit-acknowledge bit and a 6-bit priority. Software programs them through a simple write port. It sets requests and clears acknowledges with write-one semantics. It reads the masks back on dedicated outputs.

When no transmission is in flight, the arbiter looks at every mailbox that is enabled, set to transmit and requested. It grants the one with the largest priority value. A tie goes to the highest mailbox number. The grant is registered and presented as `tx_valid` plus `tx_index`. It holds until the bus side returns `tx_done`, which acknowledges the mailbox and retires its request, or `tx_abort`, which releases the grant and leaves the request pending for a retry.

The control logic has two states. ST_IDLE moves to ST_BUSY on the transition GRANT, taken when at least one mailbox is eligible. ST_BUSY returns to ST_IDLE on COMPLETE (`tx_done`) or on RELEASE (`tx_abort` without `tx_done`). If `tx_done` and `tx_abort` are high together, `tx_done` takes precedence.

Top module: `txmb_arbiter`

## Requirements
- R1: After reset, `tx_valid` is 0 and `tx_index` is 0. The enable, direction, request and acknowledge masks are all zero, and every priority is 0.
- R2: A mailbox can be granted only when its enable bit is 1, its direction bit is 0 and its request bit is 1. Write address 0 loads the enable mask. Write address 1 loads the direction mask.
- R3: Among eligible mailboxes, the grant goes to the largest priority value. Write address 4 loads the priority of mailbox `wr_mbx` from `wr_data[13:8]`. Bits 7:0 of that word do not affect arbitration.
- R4: Among eligible mailboxes that share the largest priority value, the highest-numbered one is granted.
- R5: At write address 2, each 1 bit of `wr_data` sets that mailbox's request bit. A 0 bit leaves the request bit unchanged.
- R6: `tx_done` during a grant sets the granted mailbox's acknowledge bit and clears its request bit at the same clock edge. `tx_valid` falls at that edge.
- R7: At write address 3, each 1 bit of `wr_data` clears that acknowledge bit. A 0 bit leaves it unchanged.
- R8: While a grant is held, `tx_index` and `tx_valid` stay constant. This holds even when new requests arrive or the masks are rewritten.
- R9: `tx_abort` during a grant drops `tx_valid` at the next edge and leaves the request and acknowledge bits unchanged. The mailbox is then arbitrated again.
- R10: With no eligible mailbox, `tx_valid` stays 0 and `tx_index` keeps its last value.
- R11: Arbitration runs only in ST_IDLE. `tx_valid` rises at the first clock edge after the edge that made a mailbox eligible. After a completion or release, the next grant takes one idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write target: 0 enable, 1 direction, 2 request set, 3 acknowledge clear, 4 priority word |
| wr_mbx | input | 5 | Mailbox selected by a priority-word write |
| wr_data | input | 32 | Write data |
| tx_done | input | 1 | Bus side reports the granted frame sent |
| tx_abort | input | 1 | Bus side gives up the granted frame |
| tx_valid | output | 1 | A grant is being held |
| tx_index | output | 5 | Granted mailbox number |
| en_q | output | 32 | Enable mask |
| dir_q | output | 32 | Direction mask |
| req_q | output | 32 | Transmit-request mask |
| ack_q | output | 32 | Transmit-acknowledge mask |

## Verification
The following are checked on every cycle, whatever the stimulus:
- a grant stays fixed until done or abort;
- every newly raised grant names a mailbox that was eligible one cycle earlier;
- completion sets the acknowledge bit and retires the request;
- abort leaves the request in place;
- write-one-to-set and write-one-to-clear act only on the written bits;
- the index holds while idle.

Which mailbox wins is left to the bench's scenarios. Those scenarios cover the priority order, the tie-break toward the highest number, exclusion of disabled and receive mailboxes, and the one-cycle grant latency.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
    typedef enum logic [2:0] {
        REG_ENABLE  = 3'd0,
        REG_DIR     = 3'd1,
        REG_REQ_SET = 3'd2,
        REG_ACK_CLR = 3'd3,
        REG_CTRL    = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1
    } arb_state_e;

    // priority field position inside the per-mailbox control word
    localparam int PRIO_LSB = 8;
endpackage

// File: rtl/txmb_regs.sv
module txmb_regs
    import txmb_pkg::*;
#(
    parameter int NUM_MBX = 32,
    parameter int PRIO_W  = 6,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_MBX)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [2:0]                wr_addr,
    input  logic [IDX_W-1:0]          wr_mbx,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      cmpl,
    input  logic [IDX_W-1:0]          cmpl_idx,
    output logic [NUM_MBX-1:0]        en_q,
    output logic [NUM_MBX-1:0]        dir_q,
    output logic [NUM_MBX-1:0]        req_q,
    output logic [NUM_MBX-1:0]        ack_q,
    output logic [NUM_MBX*PRIO_W-1:0] prio_flat
);
    logic [NUM_MBX-1:0] done_mask, set_mask, clr_mask;

    always_comb begin
        done_mask = cmpl ? ({{(NUM_MBX-1){1'b0}}, 1'b1} << cmpl_idx) : '0;
        set_mask  = (wr_en && wr_addr == REG_REQ_SET) ? wr_data[NUM_MBX-1:0] : '0;
        clr_mask  = (wr_en && wr_addr == REG_ACK_CLR) ? wr_data[NUM_MBX-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            dir_q <= '0;
            req_q <= '0;
            ack_q <= '0;
        end else begin
            if (wr_en && wr_addr == REG_ENABLE) en_q  <= wr_data[NUM_MBX-1:0];
            if (wr_en && wr_addr == REG_DIR)    dir_q <= wr_data[NUM_MBX-1:0];
            // a new request beats the completion retiring the same bit
            req_q <= (req_q & ~done_mask) | set_mask;
            // an acknowledge being raised beats a clear in the same cycle
            ack_q <= (ack_q & ~clr_mask) | done_mask;
        end
    end

    for (genvar g = 0; g < NUM_MBX; g++) begin : g_prio
        logic [PRIO_W-1:0] prio_r;
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_r <= '0;
            else if (wr_en && wr_addr == REG_CTRL && wr_mbx == IDX_W'(g))
                prio_r <= wr_data[PRIO_LSB +: PRIO_W];
        end
        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_r;
    end
endmodule

// File: rtl/txmb_pick.sv
module txmb_pick #(
    parameter int NUM_MBX = 32,
    parameter int PRIO_W  = 6,
    localparam int IDX_W  = $clog2(NUM_MBX)
) (
    input  logic [NUM_MBX-1:0]        elig,
    input  logic [NUM_MBX*PRIO_W-1:0] prio_flat,
    output logic                      any_elig,
    output logic [IDX_W-1:0]          win_idx
);
    logic [PRIO_W-1:0] best;

    // ascending scan with >= lets a later (higher) index take a tie
    always_comb begin
        any_elig = 1'b0;
        best     = '0;
        win_idx  = '0;
        for (int i = 0; i < NUM_MBX; i++) begin
            if (elig[i] && (!any_elig || prio_flat[i*PRIO_W +: PRIO_W] >= best)) begin
                any_elig = 1'b1;
                best     = prio_flat[i*PRIO_W +: PRIO_W];
                win_idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/txmb_fsm.sv
module txmb_fsm
    import txmb_pkg::*;
#(
    parameter int NUM_MBX = 32,
    localparam int IDX_W  = $clog2(NUM_MBX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_elig,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             tx_done,
    input  logic             tx_abort,
    output logic             tx_valid,
    output logic [IDX_W-1:0] tx_index,
    output logic             cmpl,
    output logic [IDX_W-1:0] cmpl_idx
);
    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             load;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load) idx_q <= win_idx;
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        cmpl    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_elig) begin
                    load    = 1'b1;
                    state_d = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (tx_done) begin
                    cmpl    = 1'b1;
                    state_d = ST_IDLE;
                end else if (tx_abort) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        tx_valid = (state_q == ST_BUSY);
        tx_index = idx_q;
        cmpl_idx = idx_q;
    end
endmodule

// File: rtl/txmb_arbiter.sv
module txmb_arbiter #(
    parameter int NUM_MBX = 32,
    parameter int PRIO_W  = 6,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_MBX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [IDX_W-1:0]   wr_mbx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               tx_done,
    input  logic               tx_abort,
    output logic               tx_valid,
    output logic [IDX_W-1:0]   tx_index,
    output logic [NUM_MBX-1:0] en_q,
    output logic [NUM_MBX-1:0] dir_q,
    output logic [NUM_MBX-1:0] req_q,
    output logic [NUM_MBX-1:0] ack_q
);
    logic [NUM_MBX*PRIO_W-1:0] prio_flat;
    logic [NUM_MBX-1:0]        elig;
    logic                      any_elig, cmpl;
    logic [IDX_W-1:0]          win_idx, cmpl_idx;

    txmb_regs #(.NUM_MBX(NUM_MBX), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_mbx(wr_mbx), .wr_data(wr_data), .cmpl(cmpl), .cmpl_idx(cmpl_idx),
        .en_q(en_q), .dir_q(dir_q), .req_q(req_q), .ack_q(ack_q),
        .prio_flat(prio_flat)
    );

    assign elig = en_q & ~dir_q & req_q;

    txmb_pick #(.NUM_MBX(NUM_MBX), .PRIO_W(PRIO_W)) u_pick (
        .elig(elig), .prio_flat(prio_flat), .any_elig(any_elig), .win_idx(win_idx)
    );

    txmb_fsm #(.NUM_MBX(NUM_MBX)) u_fsm (
        .clk(clk), .rst_n(rst_n), .any_elig(any_elig), .win_idx(win_idx),
        .tx_done(tx_done), .tx_abort(tx_abort), .tx_valid(tx_valid),
        .tx_index(tx_index), .cmpl(cmpl), .cmpl_idx(cmpl_idx)
    );
endmodule

// File: rtl/txmb_chk.sv
module txmb_chk
    import txmb_pkg::*;
#(
    parameter int NUM_MBX = 32,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_MBX)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [2:0]         wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic               tx_done,
    input logic               tx_abort,
    input logic               tx_valid,
    input logic [IDX_W-1:0]   tx_index,
    input logic [NUM_MBX-1:0] en_q,
    input logic [NUM_MBX-1:0] dir_q,
    input logic [NUM_MBX-1:0] req_q,
    input logic [NUM_MBX-1:0] ack_q
);
    logic [NUM_MBX-1:0] elig_d;
    always_ff @(posedge clk) begin
        if (!rst_n) elig_d <= '0;
        else        elig_d <= en_q & ~dir_q & req_q;
    end

    p_grant_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> elig_d[tx_index]);

    p_req_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_REQ_SET) |=>
            ((req_q & $past(wr_data[NUM_MBX-1:0])) == $past(wr_data[NUM_MBX-1:0])));

    p_done_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_done) |=> (ack_q[$past(tx_index)] && !tx_valid));

    p_done_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_done && !(wr_en && wr_addr == REG_REQ_SET)) |=> !req_q[$past(tx_index)]);

    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_ACK_CLR && !(tx_valid && tx_done)) |=>
            ((ack_q & $past(wr_data[NUM_MBX-1:0])) == '0));

    p_grant_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_done && !tx_abort) |=> (tx_valid && $stable(tx_index)));

    p_abort_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_abort && !tx_done) |=> (!tx_valid && req_q[$past(tx_index)]));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |=> (tx_valid || $stable(tx_index)));
endmodule

bind txmb_arbiter txmb_chk #(.NUM_MBX(NUM_MBX), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_done(tx_done), .tx_abort(tx_abort), .tx_valid(tx_valid), .tx_index(tx_index),
    .en_q(en_q), .dir_q(dir_q), .req_q(req_q), .ack_q(ack_q)
);

// File: tb/sim_txmb_arbiter.sv
module sim_txmb_arbiter;
    import txmb_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [4:0]  wr_mbx = '0;
    logic [31:0] wr_data = '0;
    logic        tx_done = 1'b0;
    logic        tx_abort = 1'b0;
    logic        tx_valid;
    logic [4:0]  tx_index;
    logic [31:0] en_q, dir_q, req_q, ack_q;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    txmb_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_mbx(wr_mbx),
        .wr_data(wr_data), .tx_done(tx_done), .tx_abort(tx_abort), .tx_valid(tx_valid),
        .tx_index(tx_index), .en_q(en_q), .dir_q(dir_q), .req_q(req_q), .ack_q(ack_q)
    );

    typedef struct packed {
        logic [31:0] en;
        logic [31:0] dir;
        logic [31:0] req;
        logic        val;
        logic [4:0]  idx;
    } vec_t;

    // priorities used: mbx3=0x3F, mbx10=0x20, mbx20=0x20, mbx7=0x05, others 0
    localparam vec_t VTAB [8] = '{
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0010_0408, 1'b1, 5'd3 },  // R3
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0010_0400, 1'b1, 5'd20},  // R4
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0081, 1'b1, 5'd7 },  // R3
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001, 1'b1, 5'd31},  // R4
        '{32'hFFFF_FFF7, 32'h0000_0000, 32'h0000_0408, 1'b1, 5'd10},  // R2 disabled
        '{32'hFFFF_FFFF, 32'h0010_0000, 32'h0010_0080, 1'b1, 5'd7 },  // R2 receive
        '{32'hFFFF_FFFF, 32'h0000_0008, 32'h0000_0008, 1'b0, 5'd0 },  // R2/R10
        '{32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 5'd0 }   // R2/R10
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [4:0] m, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_mbx = m; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_done();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk); tx_abort = 1'b1;
        @(negedge clk); tx_abort = 1'b0;
    endtask

    task automatic drain();
        wr(REG_ENABLE, 5'd0, 32'hFFFF_FFFF);
        wr(REG_DIR, 5'd0, 32'h0);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!tx_valid) break;
            tx_done = 1'b1;
            @(negedge clk);
            tx_done = 1'b0;
        end
        wr(REG_ACK_CLR, 5'd0, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [4:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", {31'b0, tx_valid}, 32'h0);
        chk("R1 index", {27'b0, tx_index}, 32'h0);
        chk("R1 masks", en_q | dir_q | req_q | ack_q, 32'h0);
        rst_n = 1'b1;

        // R1 priorities zero: all tie, highest number wins
        wr(REG_ENABLE, 5'd0, 32'hFFFF_FFFF);
        wr(REG_REQ_SET, 5'd0, 32'h0000_0003);
        @(negedge clk);
        chk("R1 prio zero tie", {27'b0, tx_index}, 32'd1);
        drain();

        // priorities; low control bits carry junk and must not matter (R3)
        wr(REG_CTRL, 5'd3,  32'h0000_3F1F);
        wr(REG_CTRL, 5'd10, 32'h0000_2017);
        wr(REG_CTRL, 5'd20, 32'h0000_2000);
        wr(REG_CTRL, 5'd7,  32'h0000_051F);

        foreach (VTAB[v]) begin
            wr(REG_ENABLE, 5'd0, VTAB[v].en);
            wr(REG_DIR, 5'd0, VTAB[v].dir);
            held = tx_index;
            wr(REG_REQ_SET, 5'd0, VTAB[v].req);
            @(negedge clk);
            chk("R2 R3 R4 vector valid", {31'b0, tx_valid}, {31'b0, VTAB[v].val});
            if (VTAB[v].val) begin
                chk("R3 R4 vector index", {27'b0, tx_index}, {27'b0, VTAB[v].idx});
                pulse_done();
                chk("R6 ack set", {31'b0, ack_q[VTAB[v].idx]}, 32'd1);
                chk("R6 req retired", {31'b0, req_q[VTAB[v].idx]}, 32'd0);
                chk("R6 valid drop", {31'b0, tx_valid}, 32'd0);
            end else begin
                chk("R10 index held", {27'b0, tx_index}, {27'b0, held});
            end
            drain();
        end

        // R5: writing zeros sets nothing
        wr(REG_REQ_SET, 5'd0, 32'h0);
        chk("R5 zero write", req_q, 32'h0);
        @(negedge clk);
        chk("R5 no grant", {31'b0, tx_valid}, 32'd0);

        // R11: grant latency
        wr(REG_REQ_SET, 5'd0, 32'h0000_0020);
        chk("R11 not yet valid", {31'b0, tx_valid}, 32'd0);
        @(negedge clk);
        chk("R11 valid next cycle", {27'b0, tx_index, 1'b0} | {31'b0, tx_valid}, {27'd5, 1'b0} | 32'd1);

        // R8: hold despite new request and mask rewrite
        wr(REG_REQ_SET, 5'd0, 32'h0000_0040);
        chk("R5 set accumulates", req_q, 32'h0000_0060);
        wr(REG_ENABLE, 5'd0, 32'h0);
        chk("R8 index held", {27'b0, tx_index}, 32'd5);
        chk("R8 valid held", {31'b0, tx_valid}, 32'd1);
        wr(REG_ENABLE, 5'd0, 32'hFFFF_FFFF);

        // R9: abort leaves state untouched, then re-arbitrates
        pulse_abort();
        chk("R9 valid drop", {31'b0, tx_valid}, 32'd0);
        chk("R9 req kept", req_q, 32'h0000_0060);
        chk("R9 ack untouched", ack_q, 32'h0);
        @(negedge clk);
        chk("R9 R4 regrant", {27'b0, tx_index}, 32'd6);
        pulse_done();
        @(negedge clk);
        chk("R11 next grant", {27'b0, tx_index}, 32'd5);
        pulse_done();
        chk("R6 both acked", ack_q, 32'h0000_0060);

        // R7: write-one-to-clear
        wr(REG_ACK_CLR, 5'd0, 32'h0000_0020);
        chk("R7 one bit cleared", ack_q, 32'h0000_0040);
        wr(REG_ACK_CLR, 5'd0, 32'h0);
        chk("R7 zero write", ack_q, 32'h0000_0040);

        // R10: idle keeps index
        repeat (3) @(negedge clk);
        chk("R10 idle valid", {31'b0, tx_valid}, 32'd0);
        chk("R10 idle index", {27'b0, tx_index}, 32'd5);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule